// File: doc/BRIEF.md
# Direct-Sequence Transmit Frame Sequencer

This block builds the serial bit stream of one direct-sequence radio frame from a set of configuration bytes and a byte-wide payload source. When the transmit-enable input rises, it sends a programmable run of sync symbols. The sync run is all ones in long mode and all zeros in short mode. A 16-bit frame delimiter follows, then three header fields taken from configuration inputs: an 8-bit rate/signal byte, an 8-bit service byte and a 16-bit length word. Every field goes out least-significant bit first.

After the header, the block pulls payload bytes over a valid/ready handshake and passes their bits through unchanged. It then appends a fixed number of zero tail bits so the transmitter can wind down cleanly, and holds silent until transmit enable drops. Each emitted bit carries a phase tag. A rate-select output shows the data modulation captured at frame start. Scrambling and modulation sit downstream, and one bit is emitted per clock.

The sequencer is a single state machine with these states:
- `ST_IDLE`: waiting for transmit enable.
- `ST_PRE`: sync run.
- `ST_SFD`: delimiter.
- `ST_SIG`, `ST_SRV`, `ST_LEN`: the header fields.
- `ST_PAY`: payload.
- `ST_TAIL`: trailing zeros.
- `ST_HOLD`: waiting for enable to drop.

Transitions:
- `ST_IDLE` moves to `ST_PRE` on enable. It goes straight to `ST_SFD` if the selected sync count is zero.
- Each field state moves to the next when its bit counter reaches zero.
- `ST_PAY` moves to `ST_TAIL` after the last bit of the byte marked last.
- `ST_TAIL` moves to `ST_HOLD` after the final tail bit.
- `ST_HOLD` moves to `ST_IDLE` when enable is low.
- Every active state returns to `ST_IDLE` as soon as enable is seen low (abort).

Top module: `dsss_frame_seq`

## Requirements
- R1: After reset the block is idle: `bit_valid` and `pay_ready` are low.
- R2: The sync run length equals `cfg_short_len` in short mode and `cfg_long_len` in long mode, with each sync bit 0 in short mode and 1 in long mode. A count of zero sends no sync bits.
- R3: The delimiter is 16 bits sent LSB first: 0xF3A0 in long mode, and its bit reversal 0x05CF in short mode.
- R4: The header is sent in this order, each field LSB first: `cfg_signal` (8 bits), then `cfg_service` (8 bits), then the length word {`cfg_len_hi`,`cfg_len_lo`} (16 bits, so `cfg_len_lo` bit 0 goes first).
- R5: Payload bytes accepted on a cycle with `pay_valid` and `pay_ready` both high are emitted unchanged, LSB first and in order. The byte accepted with `pay_last` high is the final one.
- R6: While no payload byte is available, no bit is emitted. The stream resumes with no loss or repetition when data arrives.
- R7: After the last payload bit, exactly TAIL_BITS (default 8) zero bits are emitted, and `pay_ready` stays low during them.
- R8: After the tail the block emits nothing and keeps `pay_ready` low until `tx_en` is low. It then returns to idle and can start a new frame.
- R9: If `tx_en` is low in any active state, no bit is emitted in that cycle and the block is idle in the next.
- R10: `rate_sel` takes `cfg_signal[1:0]` when a frame starts and holds it unchanged until the next frame start.
- R11: `phase_tag` with a valid bit is 0 for sync and delimiter bits, 1 for header bits, and 2 for payload and tail bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit time per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable; rising starts a frame, low ends or aborts it |
| short_mode | input | 1 | 1 selects short sync mode, 0 long |
| cfg_short_len | input | PRE_W | Sync symbol count for short mode |
| cfg_long_len | input | PRE_W | Sync symbol count for long mode |
| cfg_signal | input | 8 | Signal header byte; bits [1:0] give the data rate |
| cfg_service | input | 8 | Service header byte |
| cfg_len_lo | input | 8 | Low byte of the length word |
| cfg_len_hi | input | 8 | High byte of the length word |
| pay_data | input | 8 | Payload byte |
| pay_valid | input | 1 | Payload byte present |
| pay_last | input | 1 | Payload byte is the last of the frame |
| pay_ready | output | 1 | Block accepts a payload byte this cycle |
| bit_out | output | 1 | Serial bit |
| bit_valid | output | 1 | `bit_out` carries a frame bit this cycle |
| phase_tag | output | 2 | Phase of the current bit (0 sync, 1 header, 2 data) |
| rate_sel | output | 2 | Data rate captured at frame start |

## Verification
Long and short frames use standard and non-standard sync counts, including zero, so the run length, sync bit value and delimiter word are each distinguished per mode. Payloads are fed both back-to-back and with idle gaps, which separates correct stalling from dropped or repeated bits at byte boundaries. Header bytes with asymmetric bit patterns expose field order and bit order. A frame whose enable drops mid-sync shows the abort path, and a clean frame afterwards shows that the abort left no stale state behind. Changing the signal input mid-frame confirms that `rate_sel` stays latched.

// File: rtl/dsss_seq_pkg.sv
package dsss_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_SIG,
        ST_SRV,
        ST_LEN,
        ST_PAY,
        ST_TAIL,
        ST_HOLD
    } seq_state_t;

    localparam logic [1:0] TAG_PRE  = 2'd0;
    localparam logic [1:0] TAG_HDR  = 2'd1;
    localparam logic [1:0] TAG_DATA = 2'd2;

    localparam logic [15:0] SFD_LONG_WORD = 16'hF3A0;

endpackage

// File: rtl/dsss_mode_sel.sv
module dsss_mode_sel #(
    parameter int PRE_W = 8
) (
    input  logic             short_sel,
    input  logic [PRE_W-1:0] short_len,
    input  logic [PRE_W-1:0] long_len,
    output logic [PRE_W-1:0] pre_len,
    output logic             pre_bit,
    output logic [15:0]      sfd_word
);
    import dsss_seq_pkg::*;

    logic [15:0] sfd_rev;

    // short-mode delimiter is the long word with its bit order reversed
    for (genvar i = 0; i < 16; i++) begin : g_rev
        assign sfd_rev[i] = SFD_LONG_WORD[15-i];
    end

    assign pre_len  = short_sel ? short_len : long_len;
    assign pre_bit  = ~short_sel;
    assign sfd_word = short_sel ? sfd_rev : SFD_LONG_WORD;

endmodule

// File: rtl/dsss_frame_seq.sv
module dsss_frame_seq #(
    parameter int PRE_W     = 8,
    parameter int TAIL_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             short_mode,
    input  logic [PRE_W-1:0] cfg_short_len,
    input  logic [PRE_W-1:0] cfg_long_len,
    input  logic [7:0]       cfg_signal,
    input  logic [7:0]       cfg_service,
    input  logic [7:0]       cfg_len_lo,
    input  logic [7:0]       cfg_len_hi,
    input  logic [7:0]       pay_data,
    input  logic             pay_valid,
    input  logic             pay_last,
    output logic             pay_ready,
    output logic             bit_out,
    output logic             bit_valid,
    output logic [1:0]       phase_tag,
    output logic [1:0]       rate_sel
);
    import dsss_seq_pkg::*;

    localparam int TAIL_W = $clog2(TAIL_BITS + 1);
    localparam int MAX_A  = (PRE_W > 16) ? PRE_W : 16;
    localparam int CNT_W  = (MAX_A > TAIL_W) ? MAX_A : TAIL_W;

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [15:0]      sreg_q, sreg_d;
    logic             short_q, short_d;
    logic [1:0]       rate_q, rate_d;
    logic             have_q, have_d;
    logic             last_q, last_d;

    logic             sel_short;
    logic [PRE_W-1:0] pre_len;
    logic             pre_bit;
    logic [15:0]      sfd_word;
    logic             take;
    logic             emitting;

    assign sel_short = (state_q == ST_IDLE) ? short_mode : short_q;

    dsss_mode_sel #(.PRE_W(PRE_W)) u_mode (
        .short_sel (sel_short),
        .short_len (cfg_short_len),
        .long_len  (cfg_long_len),
        .pre_len   (pre_len),
        .pre_bit   (pre_bit),
        .sfd_word  (sfd_word)
    );

    assign take = pay_valid && pay_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sreg_q  <= '0;
            short_q <= 1'b0;
            rate_q  <= 2'd0;
            have_q  <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sreg_q  <= sreg_d;
            short_q <= short_d;
            rate_q  <= rate_d;
            have_q  <= have_d;
            last_q  <= last_d;
        end
    end

    // next state and datapath
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sreg_d  = sreg_q;
        short_d = short_q;
        rate_d  = rate_q;
        have_d  = have_q;
        last_d  = last_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_en) begin
                    short_d = short_mode;
                    rate_d  = cfg_signal[1:0];
                    if (pre_len == '0) begin
                        state_d = ST_SFD;
                        sreg_d  = sfd_word;
                        cnt_d   = CNT_W'(15);
                    end else begin
                        state_d = ST_PRE;
                        cnt_d   = CNT_W'(pre_len) - 1'b1;
                    end
                end
            end
            ST_PRE: begin
                if (cnt_q == '0) begin
                    state_d = ST_SFD;
                    sreg_d  = sfd_word;
                    cnt_d   = CNT_W'(15);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_SFD, ST_SIG, ST_SRV, ST_LEN: begin
                sreg_d = sreg_q >> 1;
                cnt_d  = cnt_q - 1'b1;
                if (cnt_q == '0) begin
                    if (state_q == ST_SFD) begin
                        state_d = ST_SIG;
                        sreg_d  = {8'h00, cfg_signal};
                        cnt_d   = CNT_W'(7);
                    end else if (state_q == ST_SIG) begin
                        state_d = ST_SRV;
                        sreg_d  = {8'h00, cfg_service};
                        cnt_d   = CNT_W'(7);
                    end else if (state_q == ST_SRV) begin
                        state_d = ST_LEN;
                        sreg_d  = {cfg_len_hi, cfg_len_lo};
                        cnt_d   = CNT_W'(15);
                    end else begin
                        state_d = ST_PAY;
                        have_d  = 1'b0;
                        last_d  = 1'b0;
                        cnt_d   = '0;
                    end
                end
            end
            ST_PAY: begin
                if (have_q) begin
                    sreg_d = sreg_q >> 1;
                    cnt_d  = cnt_q - 1'b1;
                    if (cnt_q == '0) begin
                        have_d = 1'b0;
                        if (last_q) begin
                            state_d = ST_TAIL;
                            cnt_d   = CNT_W'(TAIL_BITS - 1);
                        end
                    end
                end
                if (take) begin
                    have_d = 1'b1;
                    sreg_d = {8'h00, pay_data};
                    cnt_d  = CNT_W'(7);
                    last_d = pay_last;
                end
            end
            ST_TAIL: begin
                if (cnt_q == '0) begin
                    state_d = ST_HOLD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_HOLD: begin
                if (!tx_en) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (state_q != ST_IDLE && !tx_en) begin
            state_d = ST_IDLE;
            have_d  = 1'b0;
        end
    end

    // outputs
    always_comb begin
        emitting  = 1'b0;
        bit_out   = 1'b0;
        phase_tag = TAG_PRE;
        unique case (state_q)
            ST_PRE: begin
                emitting = 1'b1;
                bit_out  = pre_bit;
            end
            ST_SFD: begin
                emitting = 1'b1;
                bit_out  = sreg_q[0];
            end
            ST_SIG, ST_SRV, ST_LEN: begin
                emitting  = 1'b1;
                bit_out   = sreg_q[0];
                phase_tag = TAG_HDR;
            end
            ST_PAY: begin
                emitting  = have_q;
                bit_out   = have_q & sreg_q[0];
                phase_tag = TAG_DATA;
            end
            ST_TAIL: begin
                emitting  = 1'b1;
                phase_tag = TAG_DATA;
            end
            ST_IDLE, ST_HOLD: emitting = 1'b0;
            default: emitting = 1'b0;
        endcase
        bit_valid = tx_en && emitting;
        pay_ready = tx_en && (state_q == ST_PAY) &&
                    (!have_q || (cnt_q == '0 && !last_q));
    end

    assign rate_sel = rate_q;

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !bit_valid && !pay_ready) else $error("abort");  // R9

    AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_IDLE |=> $stable(rate_sel)) else $error("rate");  // R10

    AST_PAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !tx_en || (bit_valid && bit_out == $past(pay_data[0])))
        else $error("payload");  // R5

    AST_TAIL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_TAIL |-> !pay_ready && (!bit_valid || !bit_out))
        else $error("tail");  // R7

    AST_HDR_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && phase_tag == TAG_HDR) |=> !(bit_valid && phase_tag == TAG_PRE))
        else $error("order");  // R11

    AST_PRE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && state_q == ST_PRE) |-> bit_out == !short_q)
        else $error("sync");  // R2

endmodule

// File: tb/dsss_frame_seq_test.sv
module dsss_frame_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int PRE_W      = 8;
    localparam int TAIL_BITS  = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic tx_en, short_mode;
    logic [PRE_W-1:0] cfg_short_len, cfg_long_len;
    logic [7:0] cfg_signal, cfg_service, cfg_len_lo, cfg_len_hi, pay_data;
    logic pay_valid, pay_last, pay_ready, bit_out, bit_valid;
    logic [1:0] phase_tag, rate_sel;

    int errors = 0;
    int checks = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;
    logic [2:0] exp_bits[$];
    string      exp_req[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dsss_frame_seq #(.PRE_W(PRE_W), .TAIL_BITS(TAIL_BITS)) uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .short_mode(short_mode),
        .cfg_short_len(cfg_short_len), .cfg_long_len(cfg_long_len),
        .cfg_signal(cfg_signal), .cfg_service(cfg_service),
        .cfg_len_lo(cfg_len_lo), .cfg_len_hi(cfg_len_hi),
        .pay_data(pay_data), .pay_valid(pay_valid), .pay_last(pay_last),
        .pay_ready(pay_ready), .bit_out(bit_out), .bit_valid(bit_valid),
        .phase_tag(phase_tag), .rate_sel(rate_sel)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_field(input logic [15:0] v, input int n, input logic [1:0] tag,
                              input string req);
        for (int i = 0; i < n; i++) begin
            exp_bits.push_back({tag, v[i]});
            exp_req.push_back(req);
        end
    endtask

    // monitor: pop expected bits as the design emits them
    always @(negedge clk) begin
        if (rst_n && mon_on && bit_valid) begin
            if (exp_bits.size() == 0) begin
                check(1'b0, "R8 extra bit", {phase_tag, bit_out}, 0);
            end else begin
                logic [2:0] e;
                string r;
                e = exp_bits.pop_front();
                r = exp_req.pop_front();
                check({phase_tag, bit_out} == e, r, {phase_tag, bit_out}, e);
            end
        end
    end

    task automatic run_frame(input bit sm, input int plen, input logic [7:0] sig,
                             input logic [7:0] srv, input logic [15:0] len,
                             input int nbytes, input int gap);
        logic [15:0] sfd;
        logic [7:0]  b;
        sfd = sm ? 16'h05CF : 16'hF3A0;
        push_field(sm ? 16'h0000 : 16'hFFFF, 0, 2'd0, "R2");
        for (int i = 0; i < plen; i++) begin
            exp_bits.push_back({2'd0, ~sm});
            exp_req.push_back("R2 sync bit");
        end
        push_field(sfd, 16, 2'd0, "R3 delimiter");
        push_field({8'h00, sig}, 8, 2'd1, "R4 signal");
        push_field({8'h00, srv}, 8, 2'd1, "R4 service");
        push_field(len, 16, 2'd1, "R4 length");
        for (int i = 0; i < nbytes; i++) begin
            b = 8'h5A ^ 8'(i * 37);
            push_field({8'h00, b}, 8, 2'd2, "R5 payload");
        end
        push_field(16'h0000, TAIL_BITS, 2'd2, "R7 tail");
        mon_on = 1'b1;
        @(posedge clk); #1;
        short_mode = sm;
        if (sm) cfg_short_len = PRE_W'(plen); else cfg_long_len = PRE_W'(plen);
        cfg_signal = sig; cfg_service = srv;
        cfg_len_lo = len[7:0]; cfg_len_hi = len[15:8];
        tx_en = 1'b1;
        for (int i = 0; i < nbytes; i++) begin
            pay_data  = 8'h5A ^ 8'(i * 37);
            pay_last  = (i == nbytes - 1);
            pay_valid = 1'b1;
            forever begin
                @(negedge clk);
                if (pay_ready) break;
            end
            @(posedge clk); #1;
            pay_valid = 1'b0;
            if (i == 0) cfg_signal = ~sig;   // must not disturb rate_sel (R10)
            if (gap > 0) begin
                repeat (gap) @(posedge clk);
                #1;
            end
        end
        while (exp_bits.size() != 0) @(negedge clk);
        // R8: hold silent while enable stays high
        repeat (4) begin
            @(negedge clk);
            check(!bit_valid && !pay_ready, "R8 hold", {bit_valid, pay_ready}, 0);
        end
        check(rate_sel == sig[1:0], "R10 rate_sel", rate_sel, sig[1:0]);
        @(posedge clk); #1;
        tx_en = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        check(!bit_valid && !pay_ready, "R8 back to idle", {bit_valid, pay_ready}, 0);
        mon_on = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tx_en = 1'b0; short_mode = 1'b0;
        cfg_short_len = 8'h38; cfg_long_len = 8'h80;
        cfg_signal = 8'h00; cfg_service = 8'h00; cfg_len_lo = 8'h00; cfg_len_hi = 8'h00;
        pay_data = 8'h00; pay_valid = 1'b0; pay_last = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!bit_valid && !pay_ready, "R1 reset", {bit_valid, pay_ready}, 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!bit_valid && !pay_ready, "R1 idle", {bit_valid, pay_ready}, 0);

        // long frame, standard count, back-to-back payload (R2 R3 R4 R5 R7 R11)
        run_frame(1'b0, 128, 8'hA6, 8'h1C, 16'h8E21, 3, 0);
        // short frame, standard count, gaps between bytes (R6)
        run_frame(1'b1, 56, 8'h31, 8'hF0, 16'h0105, 2, 5);
        // short frame with zero sync count, single byte (R2 edge)
        run_frame(1'b1, 0, 8'h02, 8'h80, 16'h4000, 1, 0);

        // abort mid-sync (R9)
        @(posedge clk); #1;
        short_mode = 1'b0; cfg_long_len = 8'd20; tx_en = 1'b1;
        repeat (10) @(posedge clk);
        #1 tx_en = 1'b0;
        @(negedge clk);
        check(!bit_valid, "R9 abort cycle", bit_valid, 0);
        @(posedge clk); #1;
        @(negedge clk);
        check(!bit_valid && !pay_ready, "R9 idle after abort", {bit_valid, pay_ready}, 0);

        // clean long frame after abort, odd count and gaps
        run_frame(1'b0, 5, 8'hC3, 8'h55, 16'hFFFE, 2, 2);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule